// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host bus and a battery-backed static memory and decides, cycle by cycle, whether the host may read or write the array. Three supply-threshold flags arrive from analog comparators: supply above 3.0 V, above 2.8 V and above 2.5 V. Each flag is synchronized and de-glitched. The filtered levels drive a four-state sequencer: backup, recovery, normal and protected. Host strobes reach the array only in the normal state, with both upper thresholds still met.

The sequencer also steers the array's power source. The battery is selected whenever the lowest threshold is lost, but only once the backup source has been unsealed. A fresh part starts sealed. The seal opens the first time the supply is seen above 3.0 V. After that, only a dedicated factory input can close it again.

Top module: `pwg_top`

## Requirements
- R1: Reads and writes reach the array only in the normal state. Normal is entered once all three filtered flags are high.
- R2: Whenever the filtered 2.8 V flag is low, `wr_en` is 0 in that same cycle, even before the state register reacts.
- R3: Outside the normal state, `rd_en`, `wr_en` and `drive_en` are all 0 for every combination of `ce_n`, `oe_n` and `we_n`.
- R4: `batt_sel` is 1 exactly when the filtered 2.5 V flag is low and the seal is open. It returns to 0 as soon as that flag is high again.
- R5: After the 2.5 V flag returns, the block stays in recovery with all strobes blocked. It leaves recovery only when both the 2.8 V and 3.0 V flags are high.
- R6: After reset `sealed` is 1 and `batt_sel` stays 0 through any supply loss. Entering the normal state clears `sealed`.
- R7: In the normal state, `rd_en` and `drive_en` are 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. A low `we_n` turns the drivers off.
- R8: Each flag passes two synchronizer flops and a stability filter of `STABLE_CYCLES` clocks. A raw change takes effect on the enables after `STABLE_CYCLES`+2 rising edges. A pulse shorter than `STABLE_CYCLES` clocks has no effect.
- R9: If `ce_n` and `we_n` are both low while access is not allowed, `wr_en` stays 0 until `ce_n` or `we_n` returns high, even if access is allowed again before then.
- R10: Only `seal_arm`=1 sets `sealed` again. Supply cycling after the first unseal never re-seals.
- R11: In the normal state, `wr_en` is 1 exactly when `ce_n`=0 and `we_n`=0, so the write spans from the later falling edge to the earlier rising edge of the two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi | input | 1 | Comparator: supply above 3.0 V |
| sup_mid | input | 1 | Comparator: supply above 2.8 V |
| sup_lo | input | 1 | Comparator: supply above 2.5 V |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| seal_arm | input | 1 | Factory input that re-seals the backup source |
| rd_en | output | 1 | Gated array read enable |
| wr_en | output | 1 | Gated array write enable |
| drive_en | output | 1 | Data bus output-driver enable |
| batt_sel | output | 1 | 1 selects the battery as the array supply |
| sealed | output | 1 | Backup source still sealed |

## Verification
The bench builds the block with `STABLE_CYCLES`=3. This keeps each supply transition down to a handful of clocks. The filter's exact acceptance edge and the rejection of a two-clock glitch can then be checked edge by edge.

That short window leaves room to sweep all eight strobe combinations in every sequencer state. The bench also walks a full seal, unseal, backup, recovery and re-arm history. It aborts a write in flight by dropping the 2.8 V flag.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        ST_BACKUP  = 2'd0,
        ST_RECOVER = 2'd1,
        ST_NORMAL  = 2'd2,
        ST_PROTECT = 2'd3
    } pwg_state_e;

    localparam int unsigned NUM_FLAGS = 3;
    localparam int unsigned FLAG_HI   = 0;
    localparam int unsigned FLAG_MID  = 1;
    localparam int unsigned FLAG_LO   = 2;

    typedef struct packed {
        pwg_state_e state;
        logic       sealed;
    } seq_regs_t;

    typedef struct packed {
        logic wr_blk;
    } bus_regs_t;

endpackage

// File: rtl/pwg_flag_filter.sv
module pwg_flag_filter #(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          filt;
    } flt_regs_t;

    flt_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], raw};
        if (r_q.sync[1] == r_q.filt) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(STABLE_CYCLES - 1)) begin
            r_d.cnt  = '0;
            r_d.filt = r_q.sync[1];
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign filt = r_q.filt;

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.filt) |-> (r_q.filt == $past(r_q.sync[1]))) else $error("filter"); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(STABLE_CYCLES)) else $error("cnt"); // R8

endmodule

// File: rtl/pwg_seq.sv
module pwg_seq
    import pwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_f,
    input  logic       mid_f,
    input  logic       lo_f,
    input  logic       seal_arm,
    output pwg_state_e state,
    output logic       sealed
);
    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!lo_f) begin
            r_d.state = ST_BACKUP;
        end else begin
            unique case (r_q.state)
                ST_BACKUP:  r_d.state = ST_RECOVER;
                ST_RECOVER: if (hi_f && mid_f) r_d.state = ST_NORMAL;
                ST_NORMAL:  if (!hi_f || !mid_f) r_d.state = ST_PROTECT;
                ST_PROTECT: if (hi_f && mid_f) r_d.state = ST_NORMAL;
                default:    r_d.state = ST_BACKUP;
            endcase
        end
        if (seal_arm) begin
            r_d.sealed = 1'b1;
        end else if (r_d.state == ST_NORMAL && r_q.state != ST_NORMAL) begin
            r_d.sealed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_BACKUP, sealed: 1'b1};
        else        r_q <= r_d;
    end

    assign state  = r_q.state;
    assign sealed = r_q.sealed;

    AST_NORMAL_FROM_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_NORMAL && $past(r_q.state) != ST_NORMAL) |-> ($past(hi_f) && $past(mid_f))) else $error("enter"); // R5
    AST_NO_SKIP_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_BACKUP) |-> (r_q.state != ST_NORMAL)) else $error("skip"); // R5
    AST_RESEAL_ONLY_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sealed) |-> $past(seal_arm)) else $error("reseal"); // R10

endmodule

// File: rtl/pwg_top.sv
module pwg_top
    import pwg_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_hi,
    input  logic sup_mid,
    input  logic sup_lo,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic seal_arm,
    output logic rd_en,
    output logic wr_en,
    output logic drive_en,
    output logic batt_sel,
    output logic sealed
);
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] filt_flags;
    logic                 hi_f, mid_f, lo_f;
    pwg_state_e           state;
    logic                 access_ok;
    logic                 wr_req, rd_req;
    bus_regs_t            b_q, b_d;

    assign raw_flags[FLAG_HI]  = sup_hi;
    assign raw_flags[FLAG_MID] = sup_mid;
    assign raw_flags[FLAG_LO]  = sup_lo;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
        pwg_flag_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flags[g]),
            .filt (filt_flags[g])
        );
    end

    assign hi_f  = filt_flags[FLAG_HI];
    assign mid_f = filt_flags[FLAG_MID];
    assign lo_f  = filt_flags[FLAG_LO];

    pwg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_f    (hi_f),
        .mid_f   (mid_f),
        .lo_f    (lo_f),
        .seal_arm(seal_arm),
        .state   (state),
        .sealed  (sealed)
    );

    always_comb begin
        access_ok = (state == ST_NORMAL) && hi_f && mid_f && lo_f;
        wr_req    = !ce_n && !we_n;
        rd_req    = !ce_n && !oe_n && we_n;
        b_d       = b_q;
        if (!wr_req)        b_d.wr_blk = 1'b0;
        else if (!access_ok) b_d.wr_blk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign rd_en    = access_ok && rd_req;
    assign drive_en = access_ok && rd_req;
    assign wr_en    = access_ok && wr_req && !b_q.wr_blk && !(!access_ok);
    assign batt_sel = !lo_f && !sealed;

    AST_WR_NEEDS_MID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mid_f) else $error("wr mid"); // R2
    AST_QUIET_OFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL) |-> (!rd_en && !wr_en && !drive_en)) else $error("quiet"); // R3
    AST_BATT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> (!rd_en && !wr_en && !drive_en && !sealed)) else $error("batt"); // R4
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en) && !(drive_en && !we_n)) else $error("excl"); // R7
    AST_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ce_n && !we_n && !access_ok) && !ce_n && !we_n) |-> !wr_en) else $error("resume"); // R9

endmodule

// File: tb/tb_pwg_top.sv
module tb_pwg_top;
    localparam int unsigned STABLE = 3;
    localparam int unsigned SETTLE = STABLE + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_hi = 1'b0, sup_mid = 1'b0, sup_lo = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, seal_arm = 1'b0;
    logic rd_en, wr_en, drive_en, batt_sel, sealed;
    int   n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    pwg_top #(.STABLE_CYCLES(STABLE)) dut (
        .clk(clk), .rst_n(rst_n), .sup_hi(sup_hi), .sup_mid(sup_mid), .sup_lo(sup_lo),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .seal_arm(seal_arm),
        .rd_en(rd_en), .wr_en(wr_en), .drive_en(drive_en), .batt_sel(batt_sel), .sealed(sealed)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic supply(input logic h, input logic m, input logic l);
        @(negedge clk);
        sup_hi = h; sup_mid = m; sup_lo = l;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic strobes(input logic c, input logic o, input logic w);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        #1;
    endtask

    // Sweep all strobe combinations; ok says whether access is allowed.
    task automatic sweep(input string req, input logic ok);
        for (int k = 0; k < 8; k++) begin
            strobes(k[2], k[1], k[0]);
            chk({req, " rd"},  rd_en,    ok && !k[2] && !k[1] && k[0]);
            chk({req, " drv"}, drive_en, ok && !k[2] && !k[1] && k[0]);
            chk({req, " wr"},  wr_en,    ok && !k[2] && !k[0]);
        end
        strobes(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #1500000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 reset sealed", sealed, 1'b1);
        chk("R4 reset batt", batt_sel, 1'b0);
        rst_n = 1'b1;
        sweep("R3 backup", 1'b0);
        // Sealed part: supply loss never selects battery
        supply(1'b0, 1'b0, 1'b1);
        sweep("R5 recover lo", 1'b0);
        supply(1'b0, 1'b0, 1'b0);
        chk("R6 sealed no batt", batt_sel, 1'b0);
        supply(1'b0, 1'b1, 1'b1);
        sweep("R5 recover mid", 1'b0);
        chk("R6 still sealed", sealed, 1'b1);
        supply(1'b1, 1'b1, 1'b1);
        chk("R6 unseal", sealed, 1'b0);
        sweep("R1 R7 R11 normal", 1'b1);
        // Supply loss with open seal
        supply(1'b0, 1'b0, 1'b0);
        chk("R4 batt on", batt_sel, 1'b1);
        sweep("R3 backup open", 1'b0);
        supply(1'b0, 1'b0, 1'b1);
        chk("R4 batt off", batt_sel, 1'b0);
        chk("R10 no reseal", sealed, 1'b0);
        sweep("R5 recover again", 1'b0);
        supply(1'b1, 1'b1, 1'b1);
        sweep("R1 normal again", 1'b1);
        // Protected: hi lost, mid kept
        supply(1'b0, 1'b1, 1'b1);
        sweep("R3 protect", 1'b0);
        supply(1'b1, 1'b1, 1'b1);
        // R8 exact filter latency on read path
        strobes(1'b0, 1'b0, 1'b1);
        sup_hi = 1'b0;
        repeat (STABLE + 1) @(posedge clk);
        @(negedge clk);
        chk("R8 still high", rd_en, 1'b1);
        @(posedge clk); @(negedge clk);
        chk("R8 accepted", rd_en, 1'b0);
        sup_hi = 1'b1;
        repeat (SETTLE + 2) @(negedge clk);
        chk("R8 back", rd_en, 1'b1);
        // R8 glitch of STABLE-1 clocks ignored
        sup_hi = 1'b0;
        repeat (STABLE - 1) @(negedge clk);
        sup_hi = 1'b1;
        for (int i = 0; i < SETTLE; i++) begin
            @(negedge clk);
            chk("R8 glitch", rd_en, 1'b1);
        end
        // R2 / R9 abort write on mid loss
        strobes(1'b0, 1'b1, 1'b0);
        chk("R11 write on", wr_en, 1'b1);
        sup_mid = 1'b0;
        repeat (STABLE + 2) @(posedge clk);
        @(negedge clk);
        chk("R2 write cut", wr_en, 1'b0);
        supply(1'b1, 1'b1, 1'b1);
        chk("R9 no resume", wr_en, 1'b0);
        strobes(1'b0, 1'b1, 1'b1);
        strobes(1'b0, 1'b1, 1'b0);
        chk("R9 new write", wr_en, 1'b1);
        strobes(1'b1, 1'b1, 1'b1);
        // R10 re-arm
        @(negedge clk); seal_arm = 1'b1;
        @(negedge clk); seal_arm = 1'b0;
        chk("R10 armed", sealed, 1'b1);
        supply(1'b0, 1'b0, 1'b0);
        chk("R10 armed no batt", batt_sel, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule